// File: doc/BRIEF.md
# Nonvolatile Save/Restore Sequencer

This block runs the transfers between a shadow nonvolatile array and the working static array of a memory. It watches a supply-good level from a comparator, single-cycle save and restore commands from a command detector, and write requests from the bus. From these it drives phase strobes for the array: erase and program for a save, and clear and transfer for a restore. It also drives a busy flag, an output-disable and a write-inhibit. A single down-counter times each phase, and every phase length is a parameter given in clock cycles.

A save starts in one of two ways: by a software command, or by itself when the supply drops. The automatic save on power loss is skipped when nothing has been written since the last completed save or restore. A write already under way when the supply drops gets a short grace window before the save begins. A restore starts in one of two ways: by a software command, or on recovery from a low-supply condition when a restore is pending. Reset leaves a restore pending, so the first supply-good after reset brings the nonvolatile data in. A restore only reads the nonvolatile array; its contents stay as they were.

Top module: `nvsr_seq`

## Requirements
- R1: While `rst` is high, `busy` and all four phase strobes are 0 and `wr_inhibit` is 1. After reset is released with `pwr_ok` high, a restore runs: `ph_clear` for CLEAR_CYC cycles, then `ph_xfer` for XFER_PU_CYC cycles.
- R2: A `sw_store` pulse while idle with `pwr_ok` high starts a save, whether or not the array was written. `ph_erase` is high for ERASE_CYC cycles and is followed at once by `ph_prog` for PROG_CYC cycles.
- R3: A `sw_recall` pulse while idle with `pwr_ok` high gives `ph_clear` for CLEAR_CYC cycles, followed by `ph_xfer` for XFER_SW_CYC cycles.
- R4: While any phase runs, `busy`, `out_hiz` and `wr_inhibit` are all high and at most one phase strobe is high. Commands that arrive during a running operation are ignored.
- R5: While idle with `pwr_ok` high, `wr_inhibit` is 0. A write taken in this state marks the array as modified.
- R6: When `pwr_ok` falls, the array is modified, and no write is in flight, a save (erase then program, with the lengths of R2) starts on the next cycle.
- R7: When `pwr_ok` falls and the array is unmodified, no save runs, and `wr_inhibit` stays 1 until the supply returns.
- R8: A write is in flight when `wr_req` was high in the previous cycle and is still high. Such a write stays accepted in the cycle the supply falls and for up to GRACE_CYC further cycles; the save follows. A write that starts after the fall is inhibited.
- R9: A completed save or restore marks the array unmodified, so a later loss of power with no writes in between runs no save.
- R10: `sw_store` has no effect while `pwr_ok` is low.
- R11: A `sw_recall` while `pwr_ok` is low is held. The restore begins in the first cycle after `pwr_ok` returns and uses XFER_PU_CYC for its transfer phase.
- R12: When `sw_store` and `sw_recall` arrive in the same cycle, the save runs and the restore request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply above the switch threshold |
| sw_store | input | 1 | One-cycle software save command |
| sw_recall | input | 1 | One-cycle software restore command |
| wr_req | input | 1 | Bus write requested or in progress this cycle |
| busy | output | 1 | A save or restore is running |
| out_hiz | output | 1 | Data outputs must be high impedance |
| wr_inhibit | output | 1 | Bus writes are not accepted this cycle |
| ph_erase | output | 1 | Save phase 1: erase the nonvolatile array |
| ph_prog | output | 1 | Save phase 2: program the nonvolatile array |
| ph_clear | output | 1 | Restore phase 1: clear the working array |
| ph_xfer | output | 1 | Restore phase 2: copy nonvolatile data into the working array |

## Verification
The hardest case to reach is a write that is already in flight at the exact cycle the supply drops. To create it, the bench raises `wr_req` first, lowers `pwr_ok` one cycle later while holding `wr_req` high, and keeps the write held well past the grace window. It then counts how many cycles still show the write as accepted, and confirms that the save follows with full phase lengths. The companion case raises the write and lowers the supply in the same cycle, which must be refused and, with a clean array, must produce no save at all.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

    typedef enum logic [2:0] {
        ST_LOW,
        ST_READY,
        ST_GRACE,
        ST_ERASE,
        ST_PROG,
        ST_CLEAR,
        ST_XFER
    } nv_state_e;

    typedef struct packed {
        logic erase;
        logic prog;
        logic clear;
        logic xfer;
    } phase_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_busy(input nv_state_e s);
        return (s == ST_ERASE) || (s == ST_PROG) || (s == ST_CLEAR) || (s == ST_XFER);
    endfunction

    function automatic logic is_timed(input nv_state_e s);
        return is_busy(s) || (s == ST_GRACE);
    endfunction

    function automatic phase_t phase_of(input nv_state_e s);
        phase_t p;
        p.erase = (s == ST_ERASE);
        p.prog  = (s == ST_PROG);
        p.clear = (s == ST_CLEAR);
        p.xfer  = (s == ST_XFER);
        return p;
    endfunction

endpackage

// File: rtl/nvsr_timer.sv
module nvsr_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R2: an idle counter never wraps below zero
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

    // R3: a running counter moves down by exactly one per cycle
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!done && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nvsr_dirty.sv
module nvsr_dirty (
    input  logic clk,
    input  logic rst,
    input  logic wr_acc,
    input  logic clr,
    output logic dirty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b0;
        end else if (clr) begin
            dirty <= 1'b0;
        end else if (wr_acc) begin
            dirty <= 1'b1;
        end
    end

    // R5: an accepted write leaves the array marked modified
    p_mark_on_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !clr) |=> dirty);

    // R9: completion of a save or restore leaves the array clean
    p_clean_after_op_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dirty);

endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
    import nvsr_pkg::*;
#(
    parameter int unsigned ERASE_CYC   = 4,
    parameter int unsigned PROG_CYC    = 4,
    parameter int unsigned CLEAR_CYC   = 2,
    parameter int unsigned XFER_SW_CYC = 4,
    parameter int unsigned XFER_PU_CYC = 8,
    parameter int unsigned GRACE_CYC   = 2,
    parameter int unsigned W           = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_ok,
    input  logic         sw_store,
    input  logic         sw_recall,
    input  logic         wr_req,
    input  logic         dirty,
    input  logic         tmr_done,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         dirty_clr,
    output logic         wr_inhibit,
    output nv_state_e    state
);

    nv_state_e state_n;
    logic      wr_req_q;
    logic      pend_rcl;
    logic      rcl_pu;
    logic      in_flight;

    assign in_flight = wr_req && wr_req_q;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_LOW: begin
                if (pwr_ok) begin
                    state_n = (pend_rcl || sw_recall) ? ST_CLEAR : ST_READY;
                end
            end
            ST_READY: begin
                if (!pwr_ok) begin
                    if (in_flight)   state_n = ST_GRACE;
                    else if (dirty)  state_n = ST_ERASE;
                    else             state_n = ST_LOW;
                end else if (sw_store) begin
                    state_n = ST_ERASE;
                end else if (sw_recall) begin
                    state_n = ST_CLEAR;
                end
            end
            ST_GRACE: begin
                if (!wr_req || tmr_done) begin
                    state_n = dirty ? ST_ERASE : ST_LOW;
                end
            end
            ST_ERASE: if (tmr_done) state_n = ST_PROG;
            ST_PROG:  if (tmr_done) state_n = pwr_ok ? ST_READY : ST_LOW;
            ST_CLEAR: if (tmr_done) state_n = ST_XFER;
            ST_XFER:  if (tmr_done) state_n = pwr_ok ? ST_READY : ST_LOW;
            default:  state_n = ST_LOW;
        endcase
    end

    assign tmr_load = (state_n != state) && is_timed(state_n);

    always_comb begin
        unique case (state_n)
            ST_GRACE: tmr_val = W'(GRACE_CYC - 1);
            ST_ERASE: tmr_val = W'(ERASE_CYC - 1);
            ST_PROG:  tmr_val = W'(PROG_CYC - 1);
            ST_CLEAR: tmr_val = W'(CLEAR_CYC - 1);
            ST_XFER:  tmr_val = rcl_pu ? W'(XFER_PU_CYC - 1) : W'(XFER_SW_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign dirty_clr = tmr_done && ((state == ST_PROG) || (state == ST_XFER));

    always_comb begin
        unique case (state)
            ST_READY: wr_inhibit = !pwr_ok && !wr_req_q;
            ST_GRACE: wr_inhibit = !wr_req_q;
            default:  wr_inhibit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_LOW;
            wr_req_q <= 1'b0;
            pend_rcl <= 1'b1;
            rcl_pu   <= 1'b0;
        end else begin
            state    <= state_n;
            wr_req_q <= wr_req;
            if (state_n == ST_CLEAR && state != ST_CLEAR) begin
                pend_rcl <= 1'b0;
                rcl_pu   <= (state == ST_LOW);
            end else if (state == ST_LOW && sw_recall) begin
                pend_rcl <= 1'b1;
            end
        end
    end

    // R8: with the supply low, only a write that was already held is accepted
    p_grace_carry_r8: assert property (@(posedge clk) disable iff (rst)
        (!pwr_ok && !wr_inhibit) |-> $past(wr_req));

    // R7: power loss on a clean array with nothing in flight goes straight to low-power idle
    p_clean_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && !pwr_ok && !dirty && !wr_req_q) |=> (state == ST_LOW));

    // R10: no save can be launched from low-power idle
    p_low_no_store_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW) |=> (state != ST_ERASE));

    // R11: a held restore starts as soon as the supply is back
    p_pending_runs_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW && pwr_ok && pend_rcl) |=> (state == ST_CLEAR));

endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq
    import nvsr_pkg::*;
#(
    parameter int unsigned ERASE_CYC   = 500000,
    parameter int unsigned PROG_CYC    = 500000,
    parameter int unsigned CLEAR_CYC   = 100,
    parameter int unsigned XFER_SW_CYC = 1900,
    parameter int unsigned XFER_PU_CYC = 64900,
    parameter int unsigned GRACE_CYC   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic wr_req,
    output logic busy,
    output logic out_hiz,
    output logic wr_inhibit,
    output logic ph_erase,
    output logic ph_prog,
    output logic ph_clear,
    output logic ph_xfer
);

    localparam int unsigned LONGEST = max2(max2(max2(ERASE_CYC, PROG_CYC), max2(CLEAR_CYC, GRACE_CYC)),
                                           max2(XFER_SW_CYC, XFER_PU_CYC));
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    nv_state_e      state;
    phase_t         ph;
    logic           tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic           tmr_done;
    logic           dirty;
    logic           dirty_clr;
    logic           wr_acc;

    nvsr_ctrl #(
        .ERASE_CYC   (ERASE_CYC),
        .PROG_CYC    (PROG_CYC),
        .CLEAR_CYC   (CLEAR_CYC),
        .XFER_SW_CYC (XFER_SW_CYC),
        .XFER_PU_CYC (XFER_PU_CYC),
        .GRACE_CYC   (GRACE_CYC),
        .W           (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .sw_store   (sw_store),
        .sw_recall  (sw_recall),
        .wr_req     (wr_req),
        .dirty      (dirty),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .dirty_clr  (dirty_clr),
        .wr_inhibit (wr_inhibit),
        .state      (state)
    );

    nvsr_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign wr_acc = wr_req && !wr_inhibit;

    nvsr_dirty u_dirty (
        .clk    (clk),
        .rst    (rst),
        .wr_acc (wr_acc),
        .clr    (dirty_clr),
        .dirty  (dirty)
    );

    assign ph       = phase_of(state);
    assign ph_erase = ph.erase;
    assign ph_prog  = ph.prog;
    assign ph_clear = ph.clear;
    assign ph_xfer  = ph.xfer;
    assign busy     = is_busy(state);
    assign out_hiz  = busy;

    // R4: phases never overlap
    p_one_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_erase, ph_prog, ph_clear, ph_xfer}));

    // R4: a running operation shuts the bus out
    p_busy_gates_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (out_hiz && wr_inhibit));

    // R2: programming follows erase with no gap
    p_erase_then_prog_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_erase) |-> ph_prog);

    // R3: transfer follows clear with no gap
    p_clear_then_xfer_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_clear) |-> ph_xfer);

endmodule

// File: tb/nvsr_seq_test.sv
`timescale 1ns/1ps
module nvsr_seq_test;

    localparam int unsigned E_C = 3, P_C = 5, C_C = 2, XS_C = 4, XP_C = 7, G_C = 3;

    typedef struct packed {
        logic       st;
        logic       rc;
        logic [3:0] e;
        logic [3:0] p;
        logic [3:0] c;
        logic [3:0] x;
    } vec_t;

    // software command vectors in the ready state: R2, R3, R12, and no command
    localparam vec_t VEC [4] = '{
        '{1'b1, 1'b0, 4'd3, 4'd5, 4'd0, 4'd0},
        '{1'b0, 1'b1, 4'd0, 4'd0, 4'd2, 4'd4},
        '{1'b1, 1'b1, 4'd3, 4'd5, 4'd0, 4'd0},
        '{1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0}
    };

    logic clk = 1'b0;
    logic rst, pwr_ok, sw_store, sw_recall, wr_req;
    logic busy, out_hiz, wr_inhibit, ph_erase, ph_prog, ph_clear, ph_xfer;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nvsr_seq #(
        .ERASE_CYC(E_C), .PROG_CYC(P_C), .CLEAR_CYC(C_C),
        .XFER_SW_CYC(XS_C), .XFER_PU_CYC(XP_C), .GRACE_CYC(G_C)
    ) uut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .sw_store(sw_store),
        .sw_recall(sw_recall), .wr_req(wr_req), .busy(busy), .out_hiz(out_hiz),
        .wr_inhibit(wr_inhibit), .ph_erase(ph_erase), .ph_prog(ph_prog),
        .ph_clear(ph_clear), .ph_xfer(ph_xfer)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Walks n cycles; inputs change 1 ns after the edge, outputs are sampled 2 ns after it.
    task automatic win(input int n, input int inj_at, output int ce, output int cp,
                       output int cc, output int cx, output int gate_bad, output int first);
        ce = 0; cp = 0; cc = 0; cx = 0; gate_bad = 0; first = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            sw_store  = 1'b0;
            sw_recall = (i == inj_at);
            #1;
            if (ph_erase) ce++;
            if (ph_prog)  cp++;
            if (ph_clear) cc++;
            if (ph_xfer)  cx++;
            if (busy && !(out_hiz && wr_inhibit)) gate_bad++;
            if (i == 0) first = {ph_erase, ph_prog, ph_clear, ph_xfer};
        end
        @(posedge clk);
        #1;
        sw_recall = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ce, cp, cc, cx, gb, fst, acc;
        rst = 1'b1; pwr_ok = 1'b1; sw_store = 1'b0; sw_recall = 1'b0; wr_req = 1'b0;
        repeat (3) tick();
        #1;
        // R1: reset state
        chk(!busy, "R1 busy in reset", busy, 0);
        chk(wr_inhibit, "R1 inhibit in reset", wr_inhibit, 1);
        chk({ph_erase, ph_prog, ph_clear, ph_xfer} == 4'b0, "R1 phases in reset",
            {ph_erase, ph_prog, ph_clear, ph_xfer}, 0);
        tick();
        rst = 1'b0;
        win(30, -1, ce, cp, cc, cx, gb, fst);
        chk(cc == C_C, "R1 power-up clear length", cc, C_C);
        chk(cx == XP_C, "R1 power-up transfer length", cx, XP_C);
        chk(ce + cp == 0, "R1 no save on power-up", ce + cp, 0);

        // table walk: software commands while ready
        for (int k = 0; k < 4; k++) begin
            sw_store  = VEC[k].st;
            sw_recall = VEC[k].rc;
            win(30, -1, ce, cp, cc, cx, gb, fst);
            chk(ce == int'(VEC[k].e), "R2/R12 erase length", ce, VEC[k].e);
            chk(cp == int'(VEC[k].p), "R2/R12 program length", cp, VEC[k].p);
            chk(cc == int'(VEC[k].c), "R3/R12 clear length", cc, VEC[k].c);
            chk(cx == int'(VEC[k].x), "R3/R12 transfer length", cx, VEC[k].x);
            chk(gb == 0, "R4 bus gating while busy", gb, 0);
        end

        // R4: restore command during a running save is ignored
        sw_store = 1'b1;
        win(30, 3, ce, cp, cc, cx, gb, fst);
        chk(ce == E_C && cp == P_C, "R4 save unaffected", ce + cp, E_C + P_C);
        chk(cc + cx == 0, "R4 command during busy ignored", cc + cx, 0);

        // R5 then R6: write, then lose power
        wr_req = 1'b1;
        #1;
        chk(!wr_inhibit, "R5 write accepted when ready", wr_inhibit, 0);
        tick();
        wr_req = 1'b0;
        tick();
        pwr_ok = 1'b0;
        win(30, -1, ce, cp, cc, cx, gb, fst);
        chk(ce == E_C && cp == P_C, "R6 automatic save on loss", ce + cp, E_C + P_C);
        chk(wr_inhibit, "R7 writes inhibited while low", wr_inhibit, 1);
        pwr_ok = 1'b1;
        win(10, -1, ce, cp, cc, cx, gb, fst);
        chk(ce + cp + cc + cx == 0, "R9 no restore on plain recovery", ce + cp + cc + cx, 0);
        chk(!wr_inhibit, "R5 ready again", wr_inhibit, 0);
        // R9: second loss with no writes in between
        pwr_ok = 1'b0;
        win(20, -1, ce, cp, cc, cx, gb, fst);
        chk(ce + cp == 0, "R9 clean array skips save", ce + cp, 0);
        pwr_ok = 1'b1;
        win(5, -1, ce, cp, cc, cx, gb, fst);

        // R8: write in flight across the supply drop
        wr_req = 1'b1;
        tick();
        pwr_ok = 1'b0;
        #1;
        acc = 0; ce = 0; cp = 0;
        for (int i = 0; i < 30; i++) begin
            if (!wr_inhibit) acc++;
            if (ph_erase) ce++;
            if (ph_prog)  cp++;
            tick();
            #1;
        end
        chk(acc == G_C + 1, "R8 grace cycles accepted", acc, G_C + 1);
        chk(ce == E_C && cp == P_C, "R8 save after grace", ce + cp, E_C + P_C);
        wr_req = 1'b0;
        pwr_ok = 1'b1;
        win(5, -1, ce, cp, cc, cx, gb, fst);

        // R8/R7: write starting at the moment of loss is refused, clean array so no save
        pwr_ok = 1'b0;
        wr_req = 1'b1;
        #1;
        chk(wr_inhibit, "R8 new write at loss refused", wr_inhibit, 1);
        win(20, -1, ce, cp, cc, cx, gb, fst);
        chk(ce + cp == 0, "R7 clean loss no save", ce + cp, 0);
        wr_req = 1'b0;

        // R10: software save while low
        sw_store = 1'b1;
        win(20, -1, ce, cp, cc, cx, gb, fst);
        chk(ce + cp + cc + cx == 0, "R10 save blocked while low", ce + cp + cc + cx, 0);

        // R11: restore requested while low, runs on recovery
        sw_recall = 1'b1;
        win(8, -1, ce, cp, cc, cx, gb, fst);
        chk(cc + cx == 0, "R11 held while low", cc + cx, 0);
        pwr_ok = 1'b1;
        win(30, -1, ce, cp, cc, cx, gb, fst);
        chk(fst == 4'b0010, "R11 clear in first cycle", fst, 2);
        chk(cc == C_C && cx == XP_C, "R11 restore lengths", cc + cx, C_C + XP_C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule